// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers the interrupt requests of a processor subsystem and turns them into two request lines for the core: a normal request line (IRQ) and a fast request line (FIQ). The normal path has 27 sources. Sources 0 to 22 are internal synchronous level requests, and sources 23 to 26 are four external pins. Each external pin is synchronized and can be set to level or edge detection with a chosen polarity. Each normal source has an enable bit and a 3-bit priority. A combinational arbiter picks the winning source and reports its number.

The fast path is separate from the arbiter. A falling edge on an active-low pin sets a latch, and that latch drives the FIQ line directly. Enables and priorities have no effect on it.

Software sees a small word-addressed register space: enables, pending bits, a write-1-to-clear register, the external pin configuration, the winner number, the fast-latch status and the priority words. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, enables, priorities and pin configuration are zero, the pin synchronizers hold the idle-high level, nothing is pending, irq and fiq are low, and the winner register (address 4) reads 31.
- R2: Pending bit n (address 1, bits 26:0) for an internal source n in 0..22 equals int_src[n] in the same cycle.
- R3: External pin k is source 23+k and is configured at address 3, where bit 2k selects edge mode and bit 2k+1 selects the high/rising polarity. In level mode the pending bit is the pin, taken through a two-flop synchronizer, when polarity is 1, and the inverted pin when polarity is 0.
- R4: In edge mode, a rising edge (polarity 1) or a falling edge (polarity 0) of the synchronized pin sets a sticky pending bit. An edge of the opposite direction does not set it, and the bit stays set after the pin returns.
- R5: Writing 1 to bit 23+k of address 2 clears that pin's sticky bit. Writing 1 there while the pin is in level mode leaves its pending bit unchanged.
- R6: If a new qualifying edge is detected in the same cycle that its clear is written, the pending bit remains set.
- R7: The priority of source n is held in address 8+n/8, at bits 4*(n%8)+2 down to 4*(n%8). It reads back the same way. Priority 0 masks the source.
- R8: Among sources that are enabled (address 0, bit n), pending and of nonzero priority, the highest priority wins. On a tie the lowest source number wins. Address 4 bits 4:0 give the winner, or 31 if there is none.
- R9: irq is high exactly when at least one source is enabled, pending and of nonzero priority.
- R10: A falling edge of fiq_n after its two-flop synchronizer sets the fast latch, which drives fiq and address 5 bit 0. A rising edge does not set it, and enables and priorities do not affect it.
- R11: Writing 1 to bit 31 of address 2 clears the fast latch. A falling edge detected in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | 23 | Internal level requests, active high |
| ext_pin | input | 4 | External interrupt pins, asynchronous |
| fiq_n | input | 1 | Fast interrupt pin, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Normal interrupt request to the core |
| fiq | output | 1 | Fast interrupt request to the core |

## Verification
Two functions can land in the same cycle: a software clear of a sticky bit and the detection of a fresh edge on that same source. This happens both for the external edge pins and for the fast latch. The bench changes the pin on a falling clock edge and counts the two synchronizer stages. It then raises the clear write so that it lands on the very clock edge at which the new edge is latched. It then reads the pending bit, or the fiq line, and requires it to be set, before it issues a plain clear and requires the bit to drop.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_INT  = 23,
  parameter int N_EXT  = 4,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  int_src,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic              fiq_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              fiq
);
  localparam int N_SRC   = N_INT + N_EXT;
  localparam int ID_W    = 5;
  localparam int FLD_W   = 4;
  localparam int PER_W   = 8;
  localparam int CLR_FIQ = DATA_W - 1;
  localparam logic [ID_W-1:0]   NONE_ID = '1;
  localparam logic [ADDR_W-1:0] A_EN = 0, A_PEND = 1, A_CLR = 2, A_CFG = 3,
                                A_WIN = 4, A_FIQ = 5, A_PRIO = 8;

  logic [N_SRC-1:0]  en;
  logic [PRIO_W-1:0] prio [N_SRC];
  logic [N_EXT-1:0]  cfg_edge, cfg_pol;
  logic [N_EXT-1:0]  s1, s2, s3, lat, det;
  logic              f1, f2, f3, fiq_lat;
  logic [N_SRC-1:0]  pend;
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   win_id;

  wire wr_clr = reg_we && (reg_addr == A_CLR);
  wire fiq_det = f3 && !f2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      cfg_edge <= '0;
      cfg_pol  <= '0;
      for (int n = 0; n < N_SRC; n++) prio[n] <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_EN) en <= reg_wdata[N_SRC-1:0];
      if (reg_addr == A_CFG)
        for (int k = 0; k < N_EXT; k++) begin
          cfg_edge[k] <= reg_wdata[2*k];
          cfg_pol[k]  <= reg_wdata[2*k+1];
        end
      for (int n = 0; n < N_SRC; n++)
        if (reg_addr == ADDR_W'(int'(A_PRIO) + n / PER_W))
          prio[n] <= reg_wdata[FLD_W*(n % PER_W) +: PRIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; s3 <= '1;
      f1 <= 1'b1; f2 <= 1'b1; f3 <= 1'b1;
    end else begin
      s1 <= ext_pin; s2 <= s1; s3 <= s2;
      f1 <= fiq_n;   f2 <= f1; f3 <= f2;
    end
  end

  generate
    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
      assign det[k] = cfg_pol[k] ? (s2[k] && !s3[k]) : (!s2[k] && s3[k]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat[k] <= 1'b0;
        else if (cfg_edge[k] && det[k]) lat[k] <= 1'b1;
        else if (wr_clr && reg_wdata[N_INT+k]) lat[k] <= 1'b0;
      end

      assign pend[N_INT+k] = cfg_edge[k] ? lat[k] : !(s2[k] ^ cfg_pol[k]);

      // R4
      ext_latch_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat[k]) |-> $past(cfg_edge[k]));
      // R5
      ext_latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && reg_wdata[N_INT+k] && !(cfg_edge[k] && det[k])) |=> !lat[k]);
    end
  endgenerate

  assign pend[N_INT-1:0] = int_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fiq_lat <= 1'b0;
    else if (fiq_det) fiq_lat <= 1'b1;
    else if (wr_clr && reg_wdata[CLR_FIQ]) fiq_lat <= 1'b0;
  end
  assign fiq = fiq_lat;

  always_comb begin
    best_p = '0;
    win_id = NONE_ID;
    for (int n = 0; n < N_SRC; n++)
      if (en[n] && pend[n] && prio[n] > best_p) begin
        best_p = prio[n];
        win_id = ID_W'(n);
      end
  end
  assign irq = (best_p != '0);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:   reg_rdata[N_SRC-1:0] = en;
      A_PEND: reg_rdata[N_SRC-1:0] = pend;
      A_CFG:
        for (int k = 0; k < N_EXT; k++) begin
          reg_rdata[2*k]   = cfg_edge[k];
          reg_rdata[2*k+1] = cfg_pol[k];
        end
      A_WIN:  reg_rdata[ID_W-1:0] = win_id;
      A_FIQ:  reg_rdata[0] = fiq_lat;
      default:
        for (int n = 0; n < N_SRC; n++)
          if (reg_addr == ADDR_W'(int'(A_PRIO) + n / PER_W))
            reg_rdata[FLD_W*(n % PER_W) +: PRIO_W] = prio[n];
    endcase
  end

  // R10
  fiq_sets_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq) |-> $past(f3 && !f2));
  // R11
  fiq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq && !(wr_clr && reg_wdata[CLR_FIQ])) |=> fiq);
  // R9
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(pend & en)));
  // R8
  winner_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (win_id < ID_W'(N_SRC)));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] int_src = '0;
  logic [3:0]  ext_pin = 4'hF;
  logic        fiq_n = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, fiq;

  irq_prio_ctrl dut (.clk, .rst_n, .int_src, .ext_pin, .fiq_n, .reg_we,
                     .reg_addr, .reg_wdata, .reg_rdata, .irq, .fiq);

  always #10 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {31'd0, irq} : {31'd0, fiq};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string t);
    item_t it;
    reg_addr = a;
    it.kind = 0; it.exp = e; it.tag = t;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic expect_line(input int k, input logic e, input string t);
    item_t it;
    it.kind = k; it.exp = {31'd0, e}; it.tag = t;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_reg(4'd0, 32'h0, "R1 enable reset");
    expect_reg(4'd1, 32'h0, "R1 pending reset");
    expect_reg(4'd4, 32'd31, "R1 winner reset");
    expect_reg(4'd5, 32'h0, "R1 fiq status reset");
    expect_line(1, 1'b0, "R1 irq reset");
    expect_line(2, 1'b0, "R1 fiq reset");

    int_src = 23'h408;
    expect_reg(4'd1, 32'h408, "R2 internal pending");
    wr(4'd0, 32'h7FF_FFFF);
    expect_line(1, 1'b0, "R7 priority zero masks");
    expect_reg(4'd4, 32'd31, "R7 masked winner none");
    wr(4'd8, 32'h5000);
    wr(4'd9, 32'h500);
    expect_reg(4'd9, 32'h500, "R7 priority readback");
    expect_reg(4'd4, 32'd3, "R8 tie lowest number");
    expect_line(1, 1'b1, "R9 irq asserted");
    wr(4'd0, 32'h7FF_FFF7);
    expect_reg(4'd4, 32'd10, "R8 disabled source skipped");
    wr(4'd0, 32'h7FF_FFFF);
    wr(4'd10, 32'h70000);
    int_src = 23'h10_0408;
    expect_reg(4'd4, 32'd20, "R8 highest priority wins");
    int_src = '0;
    expect_line(1, 1'b0, "R9 irq drops");
    expect_reg(4'd4, 32'd31, "R8 no winner");

    ext_pin[0] = 1'b0; idle(3);
    expect_reg(4'd1, 32'h80_0000, "R3 level active low");
    ext_pin[0] = 1'b1; idle(3);
    expect_reg(4'd1, 32'h0, "R3 level low inactive");
    wr(4'd3, 32'h2);
    idle(2);
    expect_reg(4'd1, 32'h80_0000, "R3 level active high");

    wr(4'd3, 32'hE);
    ext_pin[1] = 1'b0; idle(3);
    expect_reg(4'd1, 32'h80_0000, "R4 falling ignored in rising mode");
    ext_pin[1] = 1'b1; idle(3);
    ext_pin[1] = 1'b0; idle(3);
    expect_reg(4'd1, 32'h180_0000, "R4 rising edge sticky");
    wr(4'd2, 32'h80_0000);
    expect_reg(4'd1, 32'h180_0000, "R5 level clear no effect");
    wr(4'd2, 32'h100_0000);
    expect_reg(4'd1, 32'h80_0000, "R5 edge clear");
    ext_pin[0] = 1'b0; idle(3);
    expect_reg(4'd1, 32'h0, "R5 pending empty");

    wr(4'd3, 32'h1E);
    ext_pin[2] = 1'b0;
    idle(2);
    reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h200_0000;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    expect_reg(4'd1, 32'h200_0000, "R6 edge beats clear");
    wr(4'd11, 32'h60);
    expect_reg(4'd4, 32'd25, "R8 external winner");
    wr(4'd2, 32'h200_0000);
    expect_reg(4'd1, 32'h0, "R6 later clear works");

    fiq_n = 1'b0; idle(3);
    expect_line(2, 1'b1, "R10 fiq on fall");
    expect_reg(4'd5, 32'h1, "R10 fiq status");
    expect_line(1, 1'b0, "R10 fiq independent of irq");
    wr(4'd2, 32'h8000_0000);
    expect_line(2, 1'b0, "R11 fiq clear");
    fiq_n = 1'b1; idle(3);
    expect_line(2, 1'b0, "R10 rising ignored");
    fiq_n = 1'b0;
    idle(2);
    reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h8000_0000;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    expect_line(2, 1'b1, "R11 fall beats clear");
    wr(4'd2, 32'h8000_0000);
    expect_line(2, 1'b0, "R11 clear after tie");

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule